// File: doc/BRIEF.md
# Serial ADC Channel-Select Reader

This block performs one conversion exchange with a multi-channel analog-to-digital converter over SPI. A single pulse on `start` while the block is idle begins a fixed frame of sixteen serial clock periods. Chip select is held low for the whole frame. The requested channel number is shifted out toward the converter early in the frame. The twelve result bits are gathered from the converter's data line later in the same frame.

A counter tracks the position inside the frame. That counter decides which periods carry the address and which periods carry result bits. The assembled word is written to the parallel `data` output only once the frame has finished. A one-cycle `done` pulse tells the user logic that a new value is present. The serial clock runs at the system clock divided by `2*HALF_DIV`. It rests low between frames, so the link uses SPI mode 0 timing.

Top module: `spi_adc_reader`

## Requirements
- R1: While `rst` is high, and from the first clock edge of reset onward, `cs_n` is 1, `sclk` is 0, `mosi` is 0, `done` is 0 and `data` is 0.
- R2: A `start` seen high at a clock edge while idle drives `cs_n` low from that edge. `cs_n` then stays low for exactly 32*HALF_DIV system clocks (16 serial clock periods) and rises at the edge that ends the frame.
- R3: Serial clock periods are numbered 0 to 15. Each period puts `sclk` low for HALF_DIV system clocks and then high for HALF_DIV system clocks. `sclk` is 0 whenever `cs_n` is 1.
- R4: `mosi` carries the latched channel most significant bit first: channel bit 2 in period 2, bit 1 in period 3 and bit 0 in period 4. `mosi` is 0 in every other period and between frames.
- R5: `miso` is sampled on the rising `sclk` edge of periods 4 to 15. The value from period 4 becomes `data[11]` and the value from period 15 becomes `data[0]`. `miso` in periods 0 to 3 has no effect on `data`.
- R6: `data` changes only at the edge that ends a frame and holds its value at all other times.
- R7: `done` is high for exactly one system clock: the first cycle in which `cs_n` is high again after a frame.
- R8: `chan` is latched at the edge that accepts `start`. A change of `chan` during a frame leaves that frame's `mosi` unchanged.
- R9: `start` is ignored while a frame is running. A `start` held high begins the next frame at the edge after the `done` cycle, so `cs_n` is high for exactly one clock between frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request one conversion frame |
| chan | input | CH_W | Converter channel to select |
| miso | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial command to the converter |
| done | output | 1 | One-cycle pulse when `data` is refreshed |
| data | output | RES_W | Latest conversion result |

## Verification
The bench drives `miso` high during periods 0 to 3. A design that starts shifting too early would show those ones at the top of `data` and lose the final low-order bits. The bench also changes `chan` in the middle of a frame; a design that reads the port directly instead of a latched copy would put the wrong address bits on `mosi`. It holds `start` high across frame ends to test that `cs_n` gets exactly one idle cycle, and that a running frame is never restarted. It compares `data` on every cycle, so a design that copies the shift register early would show partial results.

// File: rtl/spi_adc_reader.sv
module spi_adc_reader #(
  parameter int HALF_DIV = 2,
  parameter int CH_W     = 3,
  parameter int RES_W    = 12,
  parameter int FRAME    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CH_W-1:0]  chan,
  input  logic             miso,
  output logic             cs_n,
  output logic             sclk,
  output logic             mosi,
  output logic             done,
  output logic [RES_W-1:0] data
);
  localparam int DIV_W      = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BIT_W      = $clog2(FRAME);
  localparam int ADDR_FIRST = 2;
  localparam int ADDR_LAST  = ADDR_FIRST + CH_W - 1;
  localparam int DATA_FIRST = FRAME - RES_W;

  logic             busy;
  logic             phase;
  logic [DIV_W-1:0] div_cnt;
  logic [BIT_W-1:0] bit_cnt;
  logic [CH_W-1:0]  ch_sr;
  logic [RES_W-1:0] shreg;

  wire half_end = (div_cnt == DIV_W'(HALF_DIV - 1));
  wire in_addr  = busy && (bit_cnt >= BIT_W'(ADDR_FIRST)) && (bit_cnt <= BIT_W'(ADDR_LAST));
  wire in_data  = bit_cnt >= BIT_W'(DATA_FIRST);
  wire last_bit = (bit_cnt == BIT_W'(FRAME - 1));

  assign sclk = phase;
  assign mosi = in_addr && ch_sr[CH_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      phase   <= 1'b0;
      div_cnt <= '0;
      bit_cnt <= '0;
      ch_sr   <= '0;
      shreg   <= '0;
      cs_n    <= 1'b1;
      done    <= 1'b0;
      data    <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          cs_n    <= 1'b0;
          phase   <= 1'b0;
          div_cnt <= '0;
          bit_cnt <= '0;
          ch_sr   <= chan;
        end
      end else if (!half_end) begin
        div_cnt <= div_cnt + 1'b1;
      end else begin
        div_cnt <= '0;
        if (!phase) begin
          phase <= 1'b1;
          if (in_data) shreg <= {shreg[RES_W-2:0], miso};
        end else begin
          phase <= 1'b0;
          if (in_addr) ch_sr <= {ch_sr[CH_W-2:0], 1'b0};
          if (last_bit) begin
            busy <= 1'b0;
            cs_n <= 1'b1;
            done <= 1'b1;
            data <= shreg;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_adc_reader_chk.sv
module spi_adc_reader_chk #(
  parameter int RES_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             cs_n,
  input logic             sclk,
  input logic             mosi,
  input logic             done,
  input logic [RES_W-1:0] data
);
  // R3
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (rst) cs_n |-> !sclk);
  // R4
  mosi_idle_low_chk: assert property (@(posedge clk) disable iff (rst) cs_n |-> !mosi);
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R7
  done_on_cs_rise_chk: assert property (@(posedge clk) disable iff (rst) $rose(cs_n) |-> done);
  // R7
  cs_rise_on_done_chk: assert property (@(posedge clk) disable iff (rst) done |-> $rose(cs_n));
  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (rst) !done |-> $stable(data));
  // R2
  cs_fall_start_chk: assert property (@(posedge clk) disable iff (rst) $fell(cs_n) |-> $past(start));
endmodule

bind spi_adc_reader spi_adc_reader_chk #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .cs_n(cs_n), .sclk(sclk),
  .mosi(mosi), .done(done), .data(data)
);

// File: tb/tb_spi_adc_reader.sv
module tb_spi_adc_reader;
  localparam int H = 2;
  localparam int FRAME_CLKS = 32 * H;

  logic clk = 0, rst = 1, start = 0, miso = 0;
  logic [2:0] chan = 0;
  logic cs_n, sclk, mosi, done;
  logic [11:0] data;

  int checks = 0, fails = 0, cycles = 0;

  logic        ref_busy = 0, ref_done = 0;
  int          ref_t = 0;
  logic [2:0]  ref_ch = 0;
  logic [11:0] ref_v = 0, ref_data = 0, adc_val = 0;

  spi_adc_reader #(.HALF_DIV(H)) dut (
    .clk(clk), .rst(rst), .start(start), .chan(chan), .miso(miso),
    .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .done(done), .data(data)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      ref_busy = 0; ref_t = 0; ref_done = 0; ref_data = 0;
    end else begin
      ref_done = 0;
      if (ref_busy) begin
        ref_t++;
        if (ref_t == FRAME_CLKS) begin
          ref_busy = 0; ref_done = 1; ref_data = ref_v;
        end
      end else if (start) begin
        ref_busy = 1; ref_t = 0; ref_ch = chan; ref_v = adc_val;
      end
    end
  end

  always @(negedge clk) begin
    int k;
    bit e_sclk, e_mosi;
    k = ref_t / (2 * H);
    miso <= ref_busy ? ((k < 4) ? 1'b1 : ref_v[15 - k]) : 1'b0;
    if (!rst) begin
      e_sclk = ref_busy && (((ref_t / H) % 2) == 1);
      e_mosi = ref_busy && k >= 2 && k <= 4 && ref_ch[4 - k];
      chk(cs_n == !ref_busy, (start && ref_busy) ? "R9" : "R2", cs_n, !ref_busy);
      chk(sclk == e_sclk, "R3", sclk, e_sclk);
      chk(mosi == e_mosi, (chan != ref_ch && ref_busy) ? "R8" : "R4", mosi, e_mosi);
      chk(done == ref_done, "R7", done, ref_done);
      chk(data == ref_data, ref_done ? "R5" : "R6", data, ref_data);
    end
  end

  task automatic xact(input logic [2:0] c, input logic [11:0] v, input bit flip, input bit hold);
    @(negedge clk);
    chan = c; adc_val = v; start = 1;
    @(negedge clk);
    if (!hold) start = 0;
    repeat (5) @(negedge clk);
    if (flip) chan = ~c;
    while (!ref_done) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 1 && sclk == 0 && mosi == 0, "R1", {cs_n, sclk, mosi}, 3'b100);
    chk(done == 0 && data == 0, "R1", {done, data}, 0);
    @(negedge clk); rst = 0;
    repeat (4) @(negedge clk);
    xact(3'd5, 12'hA5C, 0, 0);
    xact(3'd2, 12'hFFF, 0, 0);
    xact(3'd7, 12'h000, 0, 0);
    xact(3'd1, 12'h801, 1, 0);
    xact(3'd4, 12'h001, 1, 0);
    xact(3'd6, 12'h3C5, 0, 1);
    xact(3'd3, 12'h7E2, 0, 1);
    xact(3'd0, 12'h555, 0, 0);
    repeat (10) @(negedge clk);
    chk(cs_n == 1 && done == 0, "R9", {cs_n, done}, 2'b10);
    chk(data == 12'h7E2 || data == 12'h555, "R6", data, ref_data);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule